// File: doc/BRIEF.md
# Sequencer Configuration Write Port

This block is the host-facing side of an address sequencer's configuration. A host drives a 7-bit bus, a chip select and a write strobe, plus a select line. The select line says whether the bus carries a register address or a data word. The strobe may come from another clock domain, so the block synchronises it and accepts one write per rising strobe edge. An address write loads an internal six-bit pointer. A data write stores its low six bits into the register the pointer names. When the data word's top bit is set, the pointer then steps forward. A run of data writes can therefore fill consecutive registers after a single address write.

The registers are 6 bits wide. Five 24-bit generator parameters are each built from four such slices. There are twenty-four crosspoint select registers, one per output bit. There are also a mode register, a test register and a start-delay register. One command address does not name a register: writing it emits a single-cycle start pulse to the sequencer. After reset is released the block holds a busy interval of 25 clocks. Every write that arrives during that interval is discarded.

Top module: `seq_cfg_port`

## Requirements
- R1: With `sel_addr` high, the low six bus bits (bit 6 ignored) load the pointer. With `sel_addr` low, the low six bus bits are stored into the register the pointer names. Two data writes with bit 6 clear land in the same register.
- R2: A data write with bus bit 6 set stores first and then advances the pointer by one. With bit 6 clear the pointer keeps its value.
- R3: Addresses with bit 5 = 1 carry a parameter index in bits 4:2 (0 to 4) and a slice index in bits 1:0. Slice 0 is parameter bits 5:0 and slice 3 is bits 23:18. Parameter p occupies `gen_param[24p+23:24p]`.
- R4: Addresses with bit 5 = 0 select crosspoint register `addr[4:0]`, which drives `xpt_sel[6i+5:6i]`. Indices 24 to 31 are ignored, and data written there changes no output.
- R5: Address 0x34 holds the mode register: skew in bits 5:3, dual enable in bit 2, run mode in bits 1:0. Address 0x35 holds the test register. Address 0x36 holds the start-delay register: enable in bit 5, delay in bits 4:0. Each stores all six data bits.
- R6: An address write of 0x3F raises `start_pulse` for exactly one clock and changes no register. A data write while the pointer is 0x3F, and an address write of any other value, raise no pulse.
- R7: `cfg_busy` rises on the first clock after reset release and stays high for exactly 25 clocks. Writes made while it is high change neither the pointer nor any register.
- R8: Reset clears the mode, test and start-delay registers and sets crosspoint register i to i. Reset leaves the five parameters unchanged.
- R9: A write takes effect only with `cs_n` low. Holding the strobe high for many clocks performs exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with the clock |
| cs_n | input | 1 | Active-low chip select |
| sel_addr | input | 1 | 1: bus holds an address, 0: bus holds data |
| wr_strb | input | 1 | Write strobe, may be asynchronous; the rising edge writes |
| din | input | 7 | Configuration bus; bit 6 is the auto-step flag on data writes |
| cfg_busy | output | 1 | High during the post-reset lockout |
| start_pulse | output | 1 | One-clock start request |
| mode_reg | output | 6 | Mode register |
| test_reg | output | 6 | Test register |
| sdly_reg | output | 6 | Start-delay register |
| xpt_sel | output | 144 | Crosspoint selects, 6 bits per output bit |
| gen_param | output | 120 | Five 24-bit generator parameters |

## Verification
A pointer that drifts is not visible at the ports until the next data write. That write then lands in a neighbouring register, so the bench reads every output after each write pattern and compares it against a full model of all registers. A wrong busy count appears as a write that either lands or vanishes around clock 25, so the bench probes that interval with a write. A strobe edge detected twice appears one write later as a skipped register. A start decode that fires on a data write shows up at once as an extra pulse in the pulse tally.

// File: rtl/seq_cfg_pkg.sv
`timescale 1ns/1ps
package seq_cfg_pkg;
  localparam int SLICE_W = 6;
  localparam int BUS_W   = 7;
  localparam int PTR_W   = 6;

  localparam logic [PTR_W-1:0] ADR_MODE  = 6'h34;
  localparam logic [PTR_W-1:0] ADR_TEST  = 6'h35;
  localparam logic [PTR_W-1:0] ADR_SDLY  = 6'h36;
  localparam logic [PTR_W-1:0] ADR_START = 6'h3F;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_XPT   = 3'd1,
    TGT_PARAM = 3'd2,
    TGT_MODE  = 3'd3,
    TGT_TEST  = 3'd4,
    TGT_SDLY  = 3'd5
  } tgt_e;
endpackage

// File: rtl/seq_cfg_strobe_sync.sv
`timescale 1ns/1ps
module seq_cfg_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_async,
  output logic strb_rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], strb_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign strb_rise = sync_q[STAGES-1] & ~prev_q;

  p_edge_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb_rise |=> !strb_rise);
endmodule

// File: rtl/seq_cfg_busy.sv
`timescale 1ns/1ps
module seq_cfg_busy #(
  parameter int BUSY_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 2);
  localparam logic [CW-1:0] CNT_INIT = CW'(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LIM  = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != '0);
    cnt_d  = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_INIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0) && (cnt_q <= CNT_LIM);

  p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cnt_q == '0) |=> !busy);
endmodule

// File: rtl/seq_cfg_decode.sv
`timescale 1ns/1ps
module seq_cfg_decode
  import seq_cfg_pkg::*;
#(
  parameter int NUM_XPT    = 24,
  parameter int NUM_PARAMS = 5
) (
  input  logic [PTR_W-1:0] ptr,
  output tgt_e             tgt,
  output logic [4:0]       xpt_idx,
  output logic [2:0]       prm_idx,
  output logic [1:0]       slc_idx
);
  localparam logic [4:0] XPT_LIM = 5'(NUM_XPT);
  localparam logic [2:0] PRM_LIM = 3'(NUM_PARAMS);

  always_comb begin
    xpt_idx = ptr[4:0];
    prm_idx = ptr[4:2];
    slc_idx = ptr[1:0];
    tgt     = TGT_NONE;
    if (!ptr[5]) begin
      if (ptr[4:0] < XPT_LIM) tgt = TGT_XPT;
    end else if (ptr[4:2] < PRM_LIM) begin
      tgt = TGT_PARAM;
    end else begin
      case (ptr)
        ADR_MODE: tgt = TGT_MODE;
        ADR_TEST: tgt = TGT_TEST;
        ADR_SDLY: tgt = TGT_SDLY;
        default:  tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/seq_cfg_regbank.sv
`timescale 1ns/1ps
module seq_cfg_regbank
  import seq_cfg_pkg::*;
#(
  parameter int NUM_XPT    = 24,
  parameter int NUM_PARAMS = 5,
  parameter int PARAM_W    = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  tgt_e                          tgt,
  input  logic [4:0]                    xpt_idx,
  input  logic [2:0]                    prm_idx,
  input  logic [1:0]                    slc_idx,
  input  logic [SLICE_W-1:0]            wdata,
  output logic [SLICE_W-1:0]            mode_q,
  output logic [SLICE_W-1:0]            test_q,
  output logic [SLICE_W-1:0]            sdly_q,
  output logic [NUM_XPT*SLICE_W-1:0]    xpt_flat,
  output logic [NUM_PARAMS*PARAM_W-1:0] prm_flat
);
  localparam int NUM_SLICES = PARAM_W / SLICE_W;

  logic mode_en, test_en, sdly_en;

  always_comb begin
    mode_en = we && (tgt == TGT_MODE);
    test_en = we && (tgt == TGT_TEST);
    sdly_en = we && (tgt == TGT_SDLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      test_q <= '0;
      sdly_q <= '0;
    end else begin
      if (mode_en) mode_q <= wdata;
      if (test_en) test_q <= wdata;
      if (sdly_en) sdly_q <= wdata;
    end
  end

  logic [SLICE_W-1:0] xpt_q [NUM_XPT];

  for (genvar i = 0; i < NUM_XPT; i++) begin : g_xpt
    logic xpt_en;
    always_comb xpt_en = we && (tgt == TGT_XPT) && (xpt_idx == 5'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      xpt_q[i] <= SLICE_W'(i);
      else if (xpt_en) xpt_q[i] <= wdata;
    end
    assign xpt_flat[i*SLICE_W +: SLICE_W] = xpt_q[i];
  end

  logic [SLICE_W-1:0] prm_q [NUM_PARAMS][NUM_SLICES];

  for (genvar p = 0; p < NUM_PARAMS; p++) begin : g_prm
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slc
      logic prm_en;
      always_comb prm_en = we && (tgt == TGT_PARAM) &&
                           (prm_idx == 3'(p)) && (slc_idx == 2'(s));
      always_ff @(posedge clk) begin
        if (prm_en) prm_q[p][s] <= wdata;
      end
      assign prm_flat[p*PARAM_W + s*SLICE_W +: SLICE_W] = prm_q[p][s];
    end
  end

  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && tgt == TGT_MODE) |=> $stable(mode_q));

  p_xpt_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && tgt == TGT_XPT) |=> $stable(xpt_flat));
endmodule

// File: rtl/seq_cfg_port.sv
`timescale 1ns/1ps
module seq_cfg_port
  import seq_cfg_pkg::*;
#(
  parameter int NUM_XPT     = 24,
  parameter int NUM_PARAMS  = 5,
  parameter int PARAM_W     = 24,
  parameter int BUSY_CYCLES = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          sel_addr,
  input  logic                          wr_strb,
  input  logic [BUS_W-1:0]              din,
  output logic                          cfg_busy,
  output logic                          start_pulse,
  output logic [SLICE_W-1:0]            mode_reg,
  output logic [SLICE_W-1:0]            test_reg,
  output logic [SLICE_W-1:0]            sdly_reg,
  output logic [NUM_XPT*SLICE_W-1:0]    xpt_sel,
  output logic [NUM_PARAMS*PARAM_W-1:0] gen_param
);
  logic             wr_edge;
  logic             wr_ok;
  logic             addr_wr, data_wr;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             start_q, start_d;
  tgt_e             tgt;
  logic [4:0]       xpt_idx;
  logic [2:0]       prm_idx;
  logic [1:0]       slc_idx;

  seq_cfg_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_async (wr_strb),
    .strb_rise  (wr_edge)
  );

  seq_cfg_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (cfg_busy)
  );

  seq_cfg_decode #(.NUM_XPT(NUM_XPT), .NUM_PARAMS(NUM_PARAMS)) u_dec (
    .ptr     (ptr_q),
    .tgt     (tgt),
    .xpt_idx (xpt_idx),
    .prm_idx (prm_idx),
    .slc_idx (slc_idx)
  );

  always_comb begin
    wr_ok   = wr_edge && !cs_n && !cfg_busy;
    addr_wr = wr_ok && sel_addr;
    data_wr = wr_ok && !sel_addr;
    ptr_d   = ptr_q;
    if (addr_wr)                ptr_d = din[PTR_W-1:0];
    else if (data_wr && din[6]) ptr_d = ptr_q + PTR_W'(1);
    start_d = addr_wr && (din[PTR_W-1:0] == ADR_START);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      start_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      start_q <= start_d;
    end
  end

  assign start_pulse = start_q;

  seq_cfg_regbank #(
    .NUM_XPT    (NUM_XPT),
    .NUM_PARAMS (NUM_PARAMS),
    .PARAM_W    (PARAM_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (data_wr),
    .tgt      (tgt),
    .xpt_idx  (xpt_idx),
    .prm_idx  (prm_idx),
    .slc_idx  (slc_idx),
    .wdata    (din[SLICE_W-1:0]),
    .mode_q   (mode_reg),
    .test_q   (test_reg),
    .sdly_q   (sdly_reg),
    .xpt_flat (xpt_sel),
    .prm_flat (gen_param)
  );

  p_ptr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy |=> $stable(ptr_q));

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_start_from_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(wr_edge));
endmodule

// File: tb/seq_cfg_port_tb.sv
`timescale 1ns/1ps
module seq_cfg_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NX = 24;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n, cs_n, sel_addr, wr_strb;
  logic [6:0] din;
  logic cfg_busy, start_pulse;
  logic [5:0] mode_reg, test_reg, sdly_reg;
  logic [NX*6-1:0] xpt_sel;
  logic [NP*24-1:0] gen_param;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int pulses = 0;
  int run = 0;
  int maxrun = 0;

  logic [5:0] xpt_exp [NX];
  logic [5:0] prm_exp [NP][4];
  logic [5:0] mode_exp, test_exp, sdly_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel_addr(sel_addr),
    .wr_strb(wr_strb), .din(din), .cfg_busy(cfg_busy),
    .start_pulse(start_pulse), .mode_reg(mode_reg), .test_reg(test_reg),
    .sdly_reg(sdly_reg), .xpt_sel(xpt_sel), .gen_param(gen_param)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && start_pulse === 1'b1) begin
      pulses++;
      run++;
      if (run > maxrun) maxrun = run;
    end else begin
      run = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [6:0] d, input logic csv, input int hold);
    @(negedge clk);
    sel_addr = a; din = d; cs_n = csv; wr_strb = 1'b1;
    repeat (hold) @(negedge clk);
    wr_strb = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic check_xpt(input string req);
    for (int i = 0; i < NX; i++) check(req, 32'(xpt_sel[i*6 +: 6]), 32'(xpt_exp[i]));
  endtask

  task automatic check_prm(input string req);
    for (int p = 0; p < NP; p++)
      check(req, 32'(gen_param[p*24 +: 24]),
            32'({prm_exp[p][3], prm_exp[p][2], prm_exp[p][1], prm_exp[p][0]}));
  endtask

  task automatic check_ctl(input string req);
    check(req, 32'(mode_reg), 32'(mode_exp));
    check(req, 32'(test_reg), 32'(test_exp));
    check(req, 32'(sdly_reg), 32'(sdly_exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int bcnt;
    int p0;
    rst_n = 1'b0; cs_n = 1'b1; sel_addr = 1'b0; wr_strb = 1'b0; din = '0;
    for (int i = 0; i < NX; i++) xpt_exp[i] = 6'(i);
    mode_exp = '0; test_exp = '0; sdly_exp = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 busy in reset", 32'(cfg_busy), 0);
    check_ctl("R8 ctl reset");
    check_xpt("R8 xpt identity");
    // R7 busy window
    rst_n = 1'b1;
    bcnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) check("R7 busy one clock after release", 32'(cfg_busy), 1);
      if (cfg_busy) bcnt++;
    end
    check("R7 busy length", 32'(bcnt), 25);

    // R2 R3 parameter fill with auto-step; bit 6 of address ignored for p=4
    for (int p = 0; p < NP; p++) begin
      bus_wr(1'b1, {(p == 4) ? 1'b1 : 1'b0, 1'b1, 3'(p), 2'b00}, 1'b0, 2);
      for (int s = 0; s < 4; s++) begin
        prm_exp[p][s] = 6'((p * 4 + s) * 5 + 3);
        bus_wr(1'b0, {1'b1, prm_exp[p][s]}, 1'b0, 2);
      end
    end
    check_prm("R3 R2 parameter slices");
    check_ctl("R2 no spill into ctl");

    // R1 data writes without step hit the same register
    bus_wr(1'b1, 7'h21, 1'b0, 2);
    bus_wr(1'b0, 7'h15, 1'b0, 2);
    bus_wr(1'b0, 7'h2A, 1'b0, 2);
    prm_exp[0][1] = 6'h2A;
    check_prm("R1 overwrite same slot");

    // R4 crosspoint sweep with auto-step
    bus_wr(1'b1, 7'h00, 1'b0, 2);
    for (int i = 0; i < NX; i++) begin
      xpt_exp[i] = 6'(23 - i);
      bus_wr(1'b0, {1'b1, 6'(23 - i)}, 1'b0, 2);
    end
    check_xpt("R4 crosspoint sweep");
    for (int a = 24; a < 32; a++) begin
      bus_wr(1'b1, 7'(a), 1'b0, 2);
      bus_wr(1'b0, 7'h3F, 1'b0, 2);
    end
    check_xpt("R4 indices above 23 ignored");
    check_ctl("R4 indices above 23 ignored");
    check_prm("R4 indices above 23 ignored");

    // R5 control registers
    bus_wr(1'b1, 7'h34, 1'b0, 2);
    bus_wr(1'b0, {1'b1, 6'h2B}, 1'b0, 2);
    bus_wr(1'b0, {1'b1, 6'h15}, 1'b0, 2);
    bus_wr(1'b0, {1'b0, 6'h3A}, 1'b0, 2);
    mode_exp = 6'h2B; test_exp = 6'h15; sdly_exp = 6'h3A;
    check_ctl("R5 mode test delay");

    // R6 start command
    p0 = pulses;
    bus_wr(1'b1, 7'h3F, 1'b0, 2);
    check("R6 one pulse", 32'(pulses - p0), 1);
    check("R6 pulse width", 32'(maxrun), 1);
    bus_wr(1'b0, 7'h3F, 1'b0, 2);
    check("R6 data at start ptr no pulse", 32'(pulses - p0), 1);
    bus_wr(1'b1, 7'h3E, 1'b0, 2);
    check("R6 other address no pulse", 32'(pulses - p0), 1);
    check_ctl("R6 registers unchanged");
    check_xpt("R6 registers unchanged");

    // R9 chip select gating
    bus_wr(1'b1, 7'h00, 1'b0, 2);
    bus_wr(1'b1, 7'h34, 1'b1, 2);
    bus_wr(1'b0, 7'h11, 1'b0, 2);
    xpt_exp[0] = 6'h11;
    check_xpt("R9 cs high ignored");
    check_ctl("R9 cs high ignored");
    // R9 long strobe writes once
    bus_wr(1'b1, 7'h01, 1'b0, 2);
    bus_wr(1'b0, {1'b1, 6'h2C}, 1'b0, 20);
    bus_wr(1'b0, {1'b0, 6'h1D}, 1'b0, 2);
    xpt_exp[1] = 6'h2C; xpt_exp[2] = 6'h1D;
    check_xpt("R9 long strobe single write");

    // R8 second reset keeps parameters
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NX; i++) xpt_exp[i] = 6'(i);
    mode_exp = '0; test_exp = '0; sdly_exp = '0;
    check_ctl("R8 ctl cleared");
    check_xpt("R8 xpt identity again");
    check_prm("R8 parameters kept");
    rst_n = 1'b1;
    // R7 writes during busy are dropped (pointer and register)
    bus_wr(1'b1, 7'h34, 1'b0, 2);
    bus_wr(1'b0, 7'h05, 1'b0, 2);
    repeat (30) @(negedge clk);
    check_ctl("R7 busy write dropped");
    bus_wr(1'b0, 7'h09, 1'b0, 2);
    xpt_exp[0] = 6'h09;
    check_xpt("R7 pointer untouched by busy write");
    check_ctl("R7 pointer untouched by busy write");

    summary();
    $finish;
  end
endmodule